// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Controller

This block sits between a clocked host and an asynchronous 512K x 16 static RAM. The host offers one word access at a time over a valid/ready handshake. Each access carries an address, a write flag, a two-bit byte-lane mask and write data. The controller turns each accepted access into a strobe sequence on the memory pins. Those pins are a 19-bit address, a pair of chip selects with opposite polarity, a write strobe, an output-enable strobe, a low-byte strobe and a high-byte strobe. The bidirectional data bus is handled as three separate signals: data out, data in and a drive enable.

Every phase length is a cycle count worked out at elaboration from nanosecond minimums and the clock-period parameter. Each count is the quotient rounded up, and never less than one cycle. The phases are address setup, write pulse, write recovery, read access and output-disable turnaround. The write pulse also covers the data-overlap minimum. The recovery phase is stretched until a full write cycle has passed, and the read access phase is stretched until a full read cycle has passed. Read data is registered on the edge that ends the access phase. It is returned with a single-cycle valid pulse, and any byte lane outside the mask reads as zero.

Top module: `sramCtrl`

## Requirements
- R1: Whenever the write strobe or output enable is active (low), the memory is selected: sramCsN is low and sramCs is high. While idle, sramCsN is high and sramCs is low.
- R2: Mask bit 0 enables the low lane (data bits 7:0) and drives sramLbN low. Mask bit 1 enables the high lane (bits 15:8) and drives sramUbN low. A lane outside the mask keeps its strobe high for the whole access.
- R3: A write holds sramWeN low for max(ceil(50/P), ceil(30/P)) consecutive cycles, where P is the clock period in ns (7 cycles at 8 ns). During the pulse, sramOeN stays high and address and data stay stable. Data is driven for at least one cycle before the pulse and at least one cycle after it.
- R4: After a write is accepted, reqReady returns after ceil(70/P) cycles (9 at 8 ns).
- R5: A read asserts sramOeN low with sramWeN high. sramDqOe is low in the cycle where output enable first goes low, and in the cycle before it.
- R6: Read data is presented with rdValid high for exactly one cycle, 1 + max(ceil(70/P), ceil(35/P)) cycles after the accept edge (10 at 8 ns).
- R7: In the returned read word, every byte lane outside the mask reads as zero. Enabled lanes carry the stored data.
- R8: After a read, sramOeN stays high for ceil(20/P) cycles before reqReady returns (13 cycles in total from accept at 8 ns). No cycle has sramDqOe high while sramOeN is low.
- R9: During and after reset, all strobes are inactive, sramDqOe is low, rdValid is low and reqReady is high.
- R10: reqReady is high only while the memory is deselected. Stored words at different addresses do not disturb each other, including the highest address 0x7FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host offers an access |
| reqReady | output | 1 | Controller can accept an access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 19 | Word address |
| reqMask | input | 2 | Byte-lane enables, bit 0 = low lane |
| reqWdata | input | 16 | Write data |
| rdValid | output | 1 | One-cycle pulse with read data |
| rdData | output | 16 | Read data, disabled lanes zero |
| sramAddr | output | 19 | Memory address |
| sramCsN | output | 1 | Active-low chip select |
| sramCs | output | 1 | Active-high chip select |
| sramWeN | output | 1 | Active-low write strobe |
| sramOeN | output | 1 | Active-low output enable |
| sramLbN | output | 1 | Active-low low-lane strobe |
| sramUbN | output | 1 | Active-low high-lane strobe |
| sramDqOut | output | 16 | Data toward the memory |
| sramDqIn | input | 16 | Data from the memory |
| sramDqOe | output | 1 | Controller drives the data bus |

## Verification
Counted from the accept edge at an 8 ns period, reqReady returns 9 edges after a write. For a read, rdValid rises 10 edges after accept and reqReady returns 13 edges after accept. The bench counts rising edges after the accept edge and samples at the following falling edge, so each count is compared against an exact value derived from the nanosecond figures. The bench's memory model only presents valid data once output enable has been low for the full access count; it shows filler bytes otherwise. A capture one cycle early therefore shows up as wrong data rather than as a latency mismatch alone. Pulse widths, lane strobes and the bus handover are measured edge by edge by monitors.

// File: rtl/sramCtrlPkg.sv
package sramCtrlPkg;

  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;

  // Strobe bundle from control to datapath
  typedef struct packed {
    logic sel;
    logic we;
    logic oe;
    logic drive;
    logic capture;
  } strobeT;

  // ceil(ns / period), never below one cycle
  function automatic int cycFor(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramCtrlFsm.sv
module sramCtrlFsm
  import sramCtrlPkg::*;
#(
  parameter int AS_CYC   = 1,
  parameter int WP_CYC   = 7,
  parameter int WR_CYC   = 1,
  parameter int RD_CYC   = 9,
  parameter int TURN_CYC = 3
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqWrite,
  output logic   reqReady,
  output logic   load,
  output strobeT strb
);

  localparam int MAXC  = maxOf(maxOf(maxOf(AS_CYC, WP_CYC), maxOf(WR_CYC, RD_CYC)), TURN_CYC);
  localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);

  typedef enum logic [2:0] {
    S_IDLE, S_WSETUP, S_WPULSE, S_WRECOV, S_RSETUP, S_RACCESS, S_RTURN
  } stateT;

  stateT state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic done;

  assign done     = (cnt == '0);
  assign reqReady = (state == S_IDLE);
  assign load     = reqValid && reqReady;

  always_comb begin
    stateNext = state;
    cntNext   = done ? cnt : cnt - 1'b1;
    case (state)
      S_IDLE: if (load) begin
        stateNext = reqWrite ? S_WSETUP : S_RSETUP;
        cntNext   = CNT_W'(AS_CYC - 1);
      end
      S_WSETUP: if (done) begin
        stateNext = S_WPULSE;
        cntNext   = CNT_W'(WP_CYC - 1);
      end
      S_WPULSE: if (done) begin
        stateNext = S_WRECOV;
        cntNext   = CNT_W'(WR_CYC - 1);
      end
      S_WRECOV: if (done) stateNext = S_IDLE;
      S_RSETUP: if (done) begin
        stateNext = S_RACCESS;
        cntNext   = CNT_W'(RD_CYC - 1);
      end
      S_RACCESS: if (done) begin
        stateNext = S_RTURN;
        cntNext   = CNT_W'(TURN_CYC - 1);
      end
      S_RTURN: if (done) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  always_comb begin
    strb = '0;
    case (state)
      S_WSETUP, S_WRECOV: begin
        strb.sel   = 1'b1;
        strb.drive = 1'b1;
      end
      S_WPULSE: begin
        strb.sel   = 1'b1;
        strb.drive = 1'b1;
        strb.we    = 1'b1;
      end
      S_RSETUP: strb.sel = 1'b1;
      S_RACCESS: begin
        strb.sel     = 1'b1;
        strb.oe      = 1'b1;
        strb.capture = done;
      end
      default: strb = '0;
    endcase
  end

endmodule

// File: rtl/sramCtrlDp.sv
module sramCtrlDp
  import sramCtrlPkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] reqWdata,
  input  strobeT            strb,
  input  logic [DATA_W-1:0] sramDqIn,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCsN,
  output logic              sramCs,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic [LANES-1:0]  laneN,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [ADDR_W-1:0] addrQ;
  logic [LANES-1:0]  maskQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] laneKeep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      maskQ  <= '0;
      wdataQ <= '0;
    end else if (load) begin
      addrQ  <= reqAddr;
      maskQ  <= reqMask;
      wdataQ <= reqWdata;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneN[g] = ~(strb.sel & maskQ[g]);
    assign laneKeep[g*LANE_W +: LANE_W] = {LANE_W{maskQ[g]}};
  end

  assign sramAddr  = addrQ;
  assign sramCsN   = ~strb.sel;
  assign sramCs    = strb.sel;
  assign sramWeN   = ~strb.we;
  assign sramOeN   = ~strb.oe;
  assign sramDqOut = wdataQ;
  assign sramDqOe  = strb.drive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.capture;
      if (strb.capture) rdData <= sramDqIn & laneKeep;
    end
  end

endmodule

// File: rtl/sramCtrl.sv
module sramCtrl
  import sramCtrlPkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_AS_NS       = 0,
  parameter int T_WP_NS       = 50,
  parameter int T_DW_NS       = 30,
  parameter int T_WR_NS       = 0,
  parameter int T_WC_NS       = 70,
  parameter int T_RC_NS       = 70,
  parameter int T_AA_NS       = 70,
  parameter int T_OE_NS       = 35,
  parameter int T_OHZ_NS      = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqMask,
  input  logic [15:0]       reqWdata,
  output logic              rdValid,
  output logic [15:0]       rdData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCsN,
  output logic              sramCs,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic              sramLbN,
  output logic              sramUbN,
  output logic [15:0]       sramDqOut,
  input  logic [15:0]       sramDqIn,
  output logic              sramDqOe
);

  localparam int AS_CYC   = cycFor(T_AS_NS, CLK_PERIOD_NS);
  localparam int WP_CYC   = maxOf(cycFor(T_WP_NS, CLK_PERIOD_NS), cycFor(T_DW_NS, CLK_PERIOD_NS));
  localparam int WR_CYC   = maxOf(cycFor(T_WR_NS, CLK_PERIOD_NS),
                                  cycFor(T_WC_NS, CLK_PERIOD_NS) - AS_CYC - WP_CYC);
  localparam int RD_CYC   = maxOf(maxOf(cycFor(T_AA_NS, CLK_PERIOD_NS), cycFor(T_OE_NS, CLK_PERIOD_NS)),
                                  cycFor(T_RC_NS, CLK_PERIOD_NS) - AS_CYC);
  localparam int TURN_CYC = cycFor(T_OHZ_NS, CLK_PERIOD_NS);

  strobeT strb;
  logic   load;
  logic [LANES-1:0] laneN;

  sramCtrlFsm #(
    .AS_CYC(AS_CYC), .WP_CYC(WP_CYC), .WR_CYC(WR_CYC),
    .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .load(load), .strb(strb)
  );

  sramCtrlDp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .load(load), .reqAddr(reqAddr), .reqMask(reqMask),
    .reqWdata(reqWdata), .strb(strb), .sramDqIn(sramDqIn), .sramAddr(sramAddr),
    .sramCsN(sramCsN), .sramCs(sramCs), .sramWeN(sramWeN), .sramOeN(sramOeN),
    .laneN(laneN), .sramDqOut(sramDqOut), .sramDqOe(sramDqOe),
    .rdData(rdData), .rdValid(rdValid)
  );

  assign sramLbN = laneN[0];
  assign sramUbN = laneN[1];

endmodule

// File: rtl/sramCtrlChk.sv
module sramCtrlChk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rdValid,
  input logic [ADDR_W-1:0] sramAddr,
  input logic              sramCsN,
  input logic              sramCs,
  input logic              sramWeN,
  input logic              sramOeN,
  input logic [15:0]       sramDqOut,
  input logic              sramDqOe
);

  assert_selected_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!sramWeN || !sramOeN) |-> (!sramCsN && sramCs));

  assert_we_oe_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(!sramWeN && !sramOeN));

  assert_pulse_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!sramWeN && $past(!sramWeN)) |-> ($stable(sramAddr) && $stable(sramDqOut)));

  assert_drive_before_we_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sramWeN) |-> ($past(sramDqOe) && sramDqOe));

  assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(sramDqOe && !sramOeN));

  assert_rdvalid_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  assert_ready_deselected_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (sramCsN && !sramCs));

endmodule

bind sramCtrl sramCtrlChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rdValid(rdValid),
  .sramAddr(sramAddr), .sramCsN(sramCsN), .sramCs(sramCs), .sramWeN(sramWeN),
  .sramOeN(sramOeN), .sramDqOut(sramDqOut), .sramDqOe(sramDqOe)
);

// File: tb/sramCtrl_tb.sv
`timescale 1ns/1ps
module sramCtrl_tb;

  localparam int P = 8;
  function automatic int cyc(input int ns);
    int c;
    c = (ns + P - 1) / P;
    return (c < 1) ? 1 : c;
  endfunction
  localparam int WP_E    = (cyc(50) > cyc(30)) ? cyc(50) : cyc(30);
  localparam int WC_E    = (cyc(70) > WP_E + 2) ? cyc(70) : WP_E + 2;
  localparam int ACC_E   = (cyc(70) > cyc(35)) ? cyc(70) : cyc(35);
  localparam int RDLAT_E = 1 + ACC_E;
  localparam int RDTOT_E = RDLAT_E + cyc(20);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [1:0]  reqMask = '0;
  logic [15:0] reqWdata = '0;
  logic        reqReady, rdValid;
  logic [15:0] rdData;
  logic [18:0] sramAddr;
  logic        sramCsN, sramCs, sramWeN, sramOeN, sramLbN, sramUbN, sramDqOe;
  logic [15:0] sramDqOut;
  logic [15:0] sramDqIn = 16'hA5A5;

  sramCtrl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqMask(reqMask), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .sramAddr(sramAddr), .sramCsN(sramCsN),
    .sramCs(sramCs), .sramWeN(sramWeN), .sramOeN(sramOeN), .sramLbN(sramLbN),
    .sramUbN(sramUbN), .sramDqOut(sramDqOut), .sramDqIn(sramDqIn), .sramDqOe(sramDqOe)
  );

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;
  logic [1:0] curMask = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Memory model: updated and driven on falling edges
  logic [15:0] mem [logic [18:0]];
  int accCnt = 0;
  always @(negedge clk) begin
    logic [15:0] word;
    logic sel;
    sel = !sramCsN && sramCs;
    word = mem.exists(sramAddr) ? mem[sramAddr] : 16'h0000;
    if (sel && !sramWeN) begin
      if (!sramLbN) word[7:0]  = sramDqOut[7:0];
      if (!sramUbN) word[15:8] = sramDqOut[15:8];
      mem[sramAddr] = word;
    end
    if (sel && sramWeN && !sramOeN) accCnt = accCnt + 1;
    else accCnt = 0;
    sramDqIn[7:0]  <= (!sramLbN && accCnt > 0) ? ((accCnt >= ACC_E) ? word[7:0]  : 8'h5A) : 8'hA5;
    sramDqIn[15:8] <= (!sramUbN && accCnt > 0) ? ((accCnt >= ACC_E) ? word[15:8] : 8'h5A) : 8'hA5;
  end

  // Pin monitors
  int weLow = 0, sinceOe = 99;
  logic prevWeN = 1'b1, prevOeN = 1'b1, prevDqOe = 1'b0, selBad = 1'b0;
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (!sramWeN) begin
        weLow++;
        if (sramCsN || !sramCs || !sramOeN) selBad = 1'b1;
      end
      if (sramWeN && !prevWeN) begin
        check(weLow == WP_E, "R3", "write pulse cycles", weLow, WP_E);
        check(!selBad, "R1", "select/oe during write pulse", selBad, 0);
        check(sramDqOe, "R3", "data held after pulse", sramDqOe, 1);
        weLow = 0;
        selBad = 1'b0;
      end
      if (!sramWeN && prevWeN)
        check({sramUbN, sramLbN} == ~curMask, "R2", "lane strobes on write",
              {sramUbN, sramLbN}, ~curMask);
      if (!sramOeN && prevOeN) begin
        check(sramWeN && !sramDqOe && !prevDqOe, "R5", "read strobes / bus released",
              {sramWeN, sramDqOe, prevDqOe}, 3'b100);
        check({sramUbN, sramLbN} == ~curMask && !sramCsN && sramCs, "R1", "read select and lanes",
              {sramCs, sramCsN, sramUbN, sramLbN}, {2'b10, ~curMask});
      end
      if (!sramOeN) sinceOe = 0;
      else if (sinceOe < 99) sinceOe++;
      if (sramDqOe && !sramOeN)
        check(1'b0, "R8", "bus driven while output enabled", 1, 0);
      if (sramDqOe && !prevDqOe)
        check(sinceOe >= 1, "R8", "turnaround before drive", sinceOe, 1);
      prevWeN = sramWeN;
      prevOeN = sramOeN;
      prevDqOe = sramDqOe;
    end
  end

  task automatic access(input bit wr, input logic [1:0] mask, input logic [18:0] addr,
                        input logic [15:0] data, input logic [15:0] exp);
    int n;
    int rdAt;
    logic [15:0] got;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqMask = mask; reqAddr = addr; reqWdata = data;
    curMask = mask;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    n = 0; rdAt = -1; got = '0;
    while (!reqReady && n < 100) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (rdValid) begin
        if (rdAt >= 0) check(1'b0, "R6", "rdValid wider than one cycle", n, rdAt);
        else begin rdAt = n; got = rdData; end
      end
    end
    if (wr) begin
      check(n == WC_E, "R4", "write cycles to ready", n, WC_E);
    end else begin
      check(rdAt == RDLAT_E, "R6", "read valid latency", rdAt, RDLAT_E);
      check(got == exp, "R7", "read data (disabled lanes zero)", got, exp);
      check(n == RDTOT_E, "R8", "read cycles to ready", n, RDTOT_E);
    end
  endtask

  // {write, mask, addr, data, expected}
  localparam int NV = 13;
  localparam logic [53:0] VEC [NV] = '{
    {1'b1, 2'b11, 19'h00010, 16'h1234, 16'h0000},
    {1'b0, 2'b11, 19'h00010, 16'h0000, 16'h1234},
    {1'b1, 2'b01, 19'h00010, 16'hAB99, 16'h0000},
    {1'b0, 2'b11, 19'h00010, 16'h0000, 16'h1299},
    {1'b1, 2'b10, 19'h00010, 16'h77FF, 16'h0000},
    {1'b0, 2'b11, 19'h00010, 16'h0000, 16'h7799},
    {1'b0, 2'b01, 19'h00010, 16'h0000, 16'h0099},
    {1'b0, 2'b10, 19'h00010, 16'h0000, 16'h7700},
    {1'b1, 2'b11, 19'h7FFFF, 16'hBEEF, 16'h0000},
    {1'b0, 2'b11, 19'h7FFFF, 16'h0000, 16'hBEEF},
    {1'b0, 2'b11, 19'h00010, 16'h0000, 16'h7799},
    {1'b1, 2'b00, 19'h00010, 16'h0000, 16'h0000},
    {1'b0, 2'b11, 19'h00010, 16'h0000, 16'h7799}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(sramCsN && !sramCs && sramWeN && sramOeN && sramLbN && sramUbN,
          "R9", "strobes idle in reset", {sramCsN, sramCs, sramWeN, sramOeN, sramLbN, sramUbN}, 6'b101111);
    check(!sramDqOe && !rdValid && reqReady, "R9", "bus/valid/ready in reset",
          {sramDqOe, rdValid, reqReady}, 3'b001);
    rstN = 1'b1;
    @(negedge clk);
    check(sramCsN && !sramCs && sramWeN && sramOeN && reqReady && !rdValid, "R9", "idle after reset",
          {sramCsN, sramCs, sramWeN, sramOeN, reqReady, rdValid}, 6'b101110);
    for (int i = 0; i < NV; i++)
      access(VEC[i][53], VEC[i][52:51], VEC[i][50:32], VEC[i][31:16], VEC[i][15:0]);
    // Directed: read directly after a write to a different lane set (R10, R2)
    access(1'b1, 2'b11, 19'h00000, 16'h0F0F, 16'h0000);
    access(1'b0, 2'b10, 19'h00000, 16'h0000, 16'h0F00);
    access(1'b0, 2'b11, 19'h7FFFF, 16'h0000, 16'hBEEF);
    // Directed: back-to-back reads, reset during idle afterwards (R9)
    rstN = 1'b0;
    @(negedge clk);
    check(reqReady && sramCsN && !sramDqOe, "R9", "re-reset idle", {reqReady, sramCsN, sramDqOe}, 3'b110);
    rstN = 1'b1;
    access(1'b0, 2'b01, 19'h00010, 16'h0000, 16'h0099);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule